// File: doc/BRIEF.md
# Parallel Bundle Issue Checker

This block sits between instruction fetch and decode. Each cycle it receives a window of three 32-bit instruction words, with word 0 at the current PC. It decides how many leading words may leave together as one bundle, one word per execution lane. It reports the bundle width, the byte amount the PC must advance, and a valid flag for each lane. The decision is registered, so it is available one clock after the window is presented.

Bundling is controlled by a continuation bit in each word. A mode input enables parallel issue. When the mode input is off, ordinary words issue one at a time. Jumbo-prefix words, recognised by a parameterised opcode, keep their continuation meaning in either mode. A candidate bundle is accepted only if:

- each member is valid in the window;
- the chain of continuation bits is well formed at both its start and its end;
- no later member touches a register that an earlier member writes.

If the full candidate is not accepted, the block falls back to a shorter bundle.

Top module: `bundle_issue_check`

## Requirements
- R1: While `rst_n` is low, `iss_width`, `pc_step` and `lane_vld` are all zero.
- R2: The outputs after a rising clock edge reflect the inputs sampled at that edge, which is one cycle of latency.
- R3: Word k occupies bits [32k+31:32k] of `fetch_win`. Within a word, bit 31 is the continuation bit, bits [30:25] the opcode, [24:20] the destination register, [19:15] the first source and [14:10] the second source. `iss_width` is the length of the longest leading run of words, up to 3, that forms a legal bundle.
- R4: `pc_step` equals 4 times `iss_width`. Bit k of `lane_vld` is 1 exactly when k is less than `iss_width`.
- R5: A word clashes with an earlier member of its bundle when the earlier word's nonzero destination equals the later word's destination or either of its sources. Register 0 never clashes. Jumbo-prefix words (opcode equal to `JUMBO_OPC`, default 6'h3E) carry no register fields. A clashing word ends the bundle before it.
- R6: In a legal bundle of two or more words, every word except the last has an effective continuation bit of 1. The last word has an effective continuation bit of 0 and is not a jumbo prefix. If this does not hold, the block falls back to fewer words. A single valid word 0 always issues alone.
- R7: A word whose bit in `word_vld` is 0 never belongs to a bundle, and no word after it does either.
- R8: When `word_vld[0]` is 0, `iss_width` and `pc_step` are 0 and `lane_vld` is all zero.
- R9: With `wide_en` low, the continuation bit of a non-jumbo word reads as 0, so such words issue alone.
- R10: The continuation bit of a jumbo-prefix word takes effect whatever the value of `wide_en`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fetch_win | input | 96 | Three instruction words, word 0 in the low bits |
| word_vld | input | 3 | Per-word valid flags |
| wide_en | input | 1 | Enables parallel issue for ordinary words |
| iss_width | output | 2 | Number of words issued this cycle (0 to 3) |
| pc_step | output | 4 | PC advance in bytes |
| lane_vld | output | 3 | Per-lane issue valid |

## Verification
The assertions check four properties on every cycle:

- the thermometer shape of `lane_vld` and its agreement with `iss_width` and `pc_step`;
- that no lane is valid unless its word was valid in the previous window;
- that a valid head word always issues and an invalid one never does;
- that ordinary words never bundle while parallel mode is off.

Only the bench's scenarios can show the following: the exact fallback width when a clash appears, where register 0 and jumbo words are exempt, the suffix rule that cuts an unterminated chain back to one word, and jumbo words bundling with the mode off.

// File: rtl/bic_pkg.sv
package bic_pkg;
   localparam int REG_W    = 5;
   localparam int CONT_BIT = 31;
   localparam int OPC_MSB  = 30;
   localparam int OPC_LSB  = 25;
   localparam int OPC_W    = OPC_MSB - OPC_LSB + 1;
   localparam int RD_LSB   = 20;
   localparam int RS1_LSB  = 15;
   localparam int RS2_LSB  = 10;

   typedef struct packed {
      logic             used;
      logic [REG_W-1:0] rd;
      logic [REG_W-1:0] rs1;
      logic [REG_W-1:0] rs2;
   } reg_info_t;
endpackage

// File: rtl/bic_word_decode.sv
module bic_word_decode
   import bic_pkg::*;
#(
   parameter logic [OPC_W-1:0] JUMBO_OPC = 6'h3E
) (
   input  logic [31:0] word_i,
   input  logic        wide_en_i,
   output reg_info_t   reg_o,
   output logic        econt_o,
   output logic        sfx_ok_o
);
   logic jumbo;
   wire  unused_low = ^word_i[RS2_LSB-1:0];

   assign jumbo    = (word_i[OPC_MSB:OPC_LSB] == JUMBO_OPC);
   // a jumbo prefix keeps its continuation meaning in either mode
   assign econt_o  = word_i[CONT_BIT] & (wide_en_i | jumbo);
   // a bundle may only end on a word that closes the chain and is not a prefix
   assign sfx_ok_o = ~econt_o & ~jumbo;

   assign reg_o.used = ~jumbo;
   assign reg_o.rd   = word_i[RD_LSB +: REG_W];
   assign reg_o.rs1  = word_i[RS1_LSB +: REG_W];
   assign reg_o.rs2  = word_i[RS2_LSB +: REG_W];
endmodule

// File: rtl/bic_clash_matrix.sv
module bic_clash_matrix
   import bic_pkg::*;
#(
   parameter int LANES = 3
) (
   input  reg_info_t [LANES-1:0] info_i,
   output logic      [LANES-1:0] clash_o
);
   always_comb begin
      clash_o = '0;
      for (int j = 1; j < LANES; j++) begin
         for (int i = 0; i < j; i++) begin
            if (info_i[i].used && info_i[j].used && (info_i[i].rd != '0) &&
                ((info_i[i].rd == info_i[j].rd)  ||
                 (info_i[i].rd == info_i[j].rs1) ||
                 (info_i[i].rd == info_i[j].rs2)))
               clash_o[j] = 1'b1;
         end
      end
   end
endmodule

// File: rtl/bic_width_select.sv
module bic_width_select #(
   parameter int LANES = 3,
   parameter int WID_W = 2
) (
   input  logic [LANES-1:0] vld_i,
   input  logic [LANES-1:0] econt_i,
   input  logic [LANES-1:0] sfx_ok_i,
   input  logic [LANES-1:0] clash_i,
   output logic [WID_W-1:0] width_o
);
   logic chain;
   wire  unused_bits = econt_i[LANES-1] ^ clash_i[0] ^ sfx_ok_i[0];

   always_comb begin
      chain   = vld_i[0];
      width_o = vld_i[0] ? WID_W'(1) : '0;
      for (int k = 1; k < LANES; k++) begin
         chain = chain & econt_i[k-1] & vld_i[k] & ~clash_i[k];
         if (chain && sfx_ok_i[k])
            width_o = WID_W'(k + 1);
      end
   end
endmodule

// File: rtl/bundle_issue_check.sv
module bundle_issue_check
   import bic_pkg::*;
#(
   parameter int               WORD_W    = 32,
   parameter int               LANES     = 3,
   parameter logic [OPC_W-1:0] JUMBO_OPC = 6'h3E,
   localparam int              WIN_W      = LANES * WORD_W,
   localparam int              WORD_BYTES = WORD_W / 8,
   localparam int              WID_W      = $clog2(LANES + 1),
   localparam int              STEP_W     = $clog2(LANES * WORD_BYTES + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [WIN_W-1:0]  fetch_win,
   input  logic [LANES-1:0]  word_vld,
   input  logic              wide_en,
   output logic [WID_W-1:0]  iss_width,
   output logic [STEP_W-1:0] pc_step,
   output logic [LANES-1:0]  lane_vld
);
   initial begin
      assert (WORD_W == 32) else $error("word layout is fixed at 32 bits");
      assert (LANES >= 2 && LANES <= 8) else $error("LANES out of range");
   end

   reg_info_t [LANES-1:0] reg_info;
   logic      [LANES-1:0] econt, sfx_ok, clash;
   logic      [WID_W-1:0] width_d;
   logic      [LANES-1:0] lane_d;

   for (genvar k = 0; k < LANES; k++) begin : g_dec
      bic_word_decode #(.JUMBO_OPC(JUMBO_OPC)) i_dec (
         .word_i   (fetch_win[k*WORD_W +: WORD_W]),
         .wide_en_i(wide_en),
         .reg_o    (reg_info[k]),
         .econt_o  (econt[k]),
         .sfx_ok_o (sfx_ok[k])
      );
      assign lane_d[k] = (width_d > WID_W'(k));
   end

   bic_clash_matrix #(.LANES(LANES)) i_clash (
      .info_i (reg_info),
      .clash_o(clash)
   );

   bic_width_select #(.LANES(LANES), .WID_W(WID_W)) i_sel (
      .vld_i   (word_vld),
      .econt_i (econt),
      .sfx_ok_i(sfx_ok),
      .clash_i (clash),
      .width_o (width_d)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         iss_width <= '0;
         pc_step   <= '0;
         lane_vld  <= '0;
      end else begin
         iss_width <= width_d;
         pc_step   <= STEP_W'(32'(width_d) * WORD_BYTES);
         lane_vld  <= lane_d;
      end
   end

   // output coherence (R4)
   p_step_match_r4: assert property (@(posedge clk) disable iff (!rst_n)
      pc_step == STEP_W'(32'(iss_width) * WORD_BYTES));
   p_lane_thermo_r4: assert property (@(posedge clk) disable iff (!rst_n)
      lane_vld == LANES'((1 << iss_width) - 1));

   // a lane only fires for a word that was present (R7)
   for (genvar k = 0; k < LANES; k++) begin : g_lane_chk
      p_lane_src_r7: assert property (@(posedge clk) disable iff (!rst_n)
         lane_vld[k] |-> $past(word_vld[k]));
   end

   // head word always issues when present, never when absent (R8)
   p_head_issue_r8: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(rst_n) && $past(word_vld[0])) |-> (iss_width != '0));
   p_head_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(word_vld[0]) |-> (iss_width == '0));

   // scalar mode: ordinary head word never bundles (R9)
   p_scalar_mode_r9: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(rst_n) && !$past(wide_en) &&
       ($past(fetch_win[OPC_MSB:OPC_LSB]) != JUMBO_OPC)) |-> (iss_width <= WID_W'(1)));
endmodule

// File: tb/test_bundle_issue_check.sv
module test_bundle_issue_check;
   localparam int CLK_PERIOD = 10;
   localparam logic [5:0] OP_N = 6'h01;
   localparam logic [5:0] OP_J = 6'h3E;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [95:0] fetch_win = '0;
   logic [2:0]  word_vld = '0;
   logic        wide_en = 1'b0;
   logic [1:0]  iss_width;
   logic [3:0]  pc_step;
   logic [2:0]  lane_vld;

   int checks = 0;
   int failures = 0;

   typedef struct {
      int    width;
      string tag;
   } exp_t;
   exp_t exp_q[$];

   bundle_issue_check i_bundle_issue_check (
      .clk(clk), .rst_n(rst_n), .fetch_win(fetch_win), .word_vld(word_vld),
      .wide_en(wide_en), .iss_width(iss_width), .pc_step(pc_step), .lane_vld(lane_vld)
   );

   always #(CLK_PERIOD/2) clk = ~clk;

   function automatic logic [31:0] mk(input logic c, input logic [5:0] op,
                                      input int rd, input int s1, input int s2);
      return {c, op, 5'(rd), 5'(s1), 5'(s2), 10'h0};
   endfunction

   task automatic check(input int act, input int exp, input string what);
      checks++;
      if (act != exp) begin
         failures++;
         $display("FAIL %s actual=%0d expected=%0d", what, act, exp);
      end
   endtask

   task automatic send(input logic [31:0] w2, input logic [31:0] w1, input logic [31:0] w0,
                       input logic [2:0] v, input logic pe, input int ew, input string tag);
      exp_t e;
      @(negedge clk);
      fetch_win = {w2, w1, w0};
      word_vld  = v;
      wide_en   = pe;
      e.width = ew;
      e.tag   = tag;
      exp_q.push_back(e);
   endtask

   task automatic finish_run();
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   endtask

   // monitor: one result per pushed window, one edge later (R2)
   always begin
      @(posedge clk);
      #1;
      if (exp_q.size() > 0) begin
         exp_t e;
         e = exp_q.pop_front();
         check(int'(iss_width), e.width, {e.tag, " R2 width"});
         check(int'(pc_step), 4 * e.width, {e.tag, " R4 step"});
         check(int'(lane_vld), (1 << e.width) - 1, {e.tag, " R4 lanes"});
      end
   end

   initial begin
      #(CLK_PERIOD * 2000);
      failures++;
      $display("FAIL watchdog R2 actual=timeout expected=completion");
      finish_run();
   end

   initial begin
      fetch_win = {mk(0,OP_N,5,0,0), mk(1,OP_N,4,0,0), mk(1,OP_N,3,0,0)};
      word_vld  = 3'b111;
      wide_en   = 1'b1;
      repeat (3) @(posedge clk);
      #1;
      check(int'(iss_width), 0, "R1 reset width");
      check(int'(pc_step), 0, "R1 reset step");
      check(int'(lane_vld), 0, "R1 reset lanes");
      @(negedge clk);
      rst_n = 1'b1;
      word_vld = '0;

      // R3 basic widths
      send(mk(0,OP_N,5,6,7), mk(1,OP_N,2,3,4), mk(1,OP_N,1,8,9), 3'b111, 1, 3, "R3 three linked");
      send(mk(0,OP_N,5,6,7), mk(0,OP_N,2,3,4), mk(0,OP_N,1,8,9), 3'b111, 1, 1, "R3 no link");
      send(mk(0,OP_N,5,6,7), mk(0,OP_N,2,3,4), mk(1,OP_N,1,8,9), 3'b111, 1, 2, "R3 pair");
      // R5 clash
      send(mk(0,OP_N,5,6,7), mk(0,OP_N,2,1,4), mk(1,OP_N,1,8,9), 3'b111, 1, 1, "R5 read after write");
      send(mk(0,OP_N,5,6,7), mk(0,OP_N,1,3,4), mk(1,OP_N,1,8,9), 3'b111, 1, 1, "R5 write after write");
      send(mk(0,OP_N,5,1,7), mk(1,OP_N,2,3,4), mk(1,OP_N,1,8,9), 3'b111, 1, 1, "R5 word2 vs word0");
      send(mk(0,OP_N,5,2,7), mk(1,OP_N,2,3,4), mk(1,OP_N,1,8,9), 3'b111, 1, 1, "R5 word2 vs word1");
      send(mk(0,OP_N,5,0,0), mk(0,OP_N,0,0,3), mk(1,OP_N,0,8,9), 3'b111, 1, 2, "R5 register zero");
      send(mk(0,OP_N,5,6,7), mk(0,OP_N,2,5,4), mk(1,OP_J,5,5,5), 3'b111, 1, 2, "R5 jumbo fields");
      // R6 suffix rules
      send(mk(1,OP_N,5,6,7), mk(1,OP_N,2,3,4), mk(1,OP_N,1,8,9), 3'b111, 1, 1, "R6 open chain");
      send(mk(0,OP_N,5,6,7), mk(0,OP_J,2,3,4), mk(1,OP_N,1,8,9), 3'b111, 1, 1, "R6 jumbo suffix");
      send(mk(0,OP_N,5,6,7), mk(1,OP_J,2,3,4), mk(1,OP_J,1,8,9), 3'b111, 1, 3, "R6 two prefixes");
      // R7 / R8 valid bits
      send(mk(0,OP_N,5,6,7), mk(1,OP_N,2,3,4), mk(1,OP_N,1,8,9), 3'b011, 1, 1, "R7 tail missing");
      send(mk(0,OP_N,5,6,7), mk(0,OP_N,2,3,4), mk(1,OP_N,1,8,9), 3'b011, 1, 2, "R7 pair without tail");
      send(mk(0,OP_N,5,6,7), mk(0,OP_N,2,3,4), mk(1,OP_N,1,8,9), 3'b101, 1, 1, "R7 middle missing");
      send(mk(0,OP_N,5,6,7), mk(0,OP_N,2,3,4), mk(1,OP_N,1,8,9), 3'b110, 1, 0, "R8 head missing");
      // R9 / R10 mode flag
      send(mk(0,OP_N,5,6,7), mk(1,OP_N,2,3,4), mk(1,OP_N,1,8,9), 3'b111, 0, 1, "R9 scalar mode");
      send(mk(0,OP_N,5,6,7), mk(1,OP_N,2,3,4), mk(1,OP_J,1,8,9), 3'b111, 0, 2, "R10 jumbo in scalar mode");
      send(mk(0,OP_N,5,6,7), mk(1,OP_J,2,3,4), mk(1,OP_J,1,8,9), 3'b111, 0, 3, "R10 prefixes in scalar mode");
      send(mk(0,OP_N,5,6,7), mk(1,OP_N,2,3,4), mk(1,OP_N,1,8,9), 3'b111, 1, 3, "R9 mode restored");

      @(negedge clk);
      word_vld = '0;
      repeat (3) @(posedge clk);
      #2;
      check(exp_q.size(), 0, "R2 queue drained");
      finish_run();
   end
endmodule